// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor's load/store port and a slower word-addressed memory. Every set holds two ways. Each way has a valid bit, a tag and one data word. Both tags of the indexed set are compared against the request in the same cycle. A read hit returns its word combinationally, with no stall. A read miss stalls the processor and fetches the word over a request/acknowledge port. The word is then placed in an invalid way if the set has one, and otherwise in the way that was referenced less recently. One bit per set tracks that order.

Stores always travel toward memory through a four-entry first-in first-out buffer, which the memory empties over a valid/ready drain port. A store that hits also updates the cached word. A store that misses leaves the cache untouched. The processor waits on a store only when the buffer is full. A read miss whose address is still waiting in the buffer holds off its memory read until that entry has drained, so the fill always sees the newest value.

Top module: `wt2_cache`

## Requirements
- R1: After reset every way is invalid and the store buffer is empty. With no request, `cpu_stall`, `wb_valid` and `mem_rd_req` are all low, and the first read of any address fetches from memory.
- R2: The low `log2(SETS)` bits of the word address select the set, and the remaining bits form the tag. Two addresses that share a set can be resident together, so the reads 0,4,0,4,0,4,0,4 cause exactly two memory reads.
- R3: A read that hits completes in the cycle it is presented. `cpu_stall` is low, `cpu_rdata` holds the word from the matching way, and no memory read is issued.
- R4: On a read miss the word is installed in an invalid way of the set if one exists. Otherwise it replaces the way that was not referenced most recently.
- R5: A store that hits overwrites the matching way's word and counts as a reference to that way for replacement.
- R6: A store that misses does not allocate, so a later read of that address still misses.
- R7: Every accepted store appears on the drain port as its address and data, in acceptance order. Each entry is held stable until `wb_ready` is high.
- R8: The buffer holds four stores. A store is accepted without stall while the buffer has room, and stalls while it is full.
- R9: A read miss to an address with a pending store in the buffer keeps `mem_rd_req` low until that entry has drained. It then returns the stored value.
- R10: During a fill, `mem_rd_req` stays high with `mem_rd_addr` equal to the missing address until `mem_rd_ack`. The word returned on `mem_rd_data` is then installed and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until not stalled |
| cpu_we | input | 1 | 1 for store, 0 for read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data, valid when a read is not stalled |
| cpu_stall | output | 1 | Access not complete this cycle |
| mem_rd_req | output | 1 | Fill request to memory |
| mem_rd_addr | output | ADDR_W | Fill address |
| mem_rd_ack | input | 1 | Fill data valid, one-cycle pulse |
| mem_rd_data | input | DATA_W | Fill data |
| wb_valid | output | 1 | Drain entry available |
| wb_addr | output | ADDR_W | Drain entry address |
| wb_data | output | DATA_W | Drain entry data |
| wb_ready | input | 1 | Memory takes the drain entry |

## Verification
The bench runs the alternating-conflict read string and counts fills; a design that indexed without associativity would fetch eight times instead of two. It then brings in a third tag after a store hit, so a design that forgot to treat store hits as references evicts the wrong way and the following read misses. A store miss followed by a read of the same address exposes a design that allocates on stores. A read held behind its own pending store catches a fill issued too early, because the fill would return stale memory data. Four stores with the drain blocked, followed by a fifth, check both that the full buffer stalls and that the drain comes out in first-in order.

// File: rtl/cw_pkg.sv
package cw_pkg;
   typedef enum logic {
      ST_LOOKUP = 1'b0,
      ST_FILL   = 1'b1
   } cache_state_t;
endpackage

// File: rtl/cw_way_bank.sv
module cw_way_bank #(
   parameter int SETS   = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n)     valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/cw_lru_bits.sv
module cw_lru_bits #(
   parameter int SETS = 4,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             way0_valid,
   input  logic             way1_valid,
   input  logic             touch_en,
   input  logic             touch_way,
   output logic             victim
);
   // per set: the way to evict next when both ways are valid
   logic [SETS-1:0] evict_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        evict_q <= '0;
      else if (touch_en) evict_q[idx] <= ~touch_way;
   end

   always_comb begin
      if (!way0_valid)      victim = 1'b0;
      else if (!way1_valid) victim = 1'b1;
      else                  victim = evict_q[idx];
   end
endmodule

// File: rtl/cw_store_queue.sv
module cw_store_queue #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              head_valid,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              full,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit
);
   logic [ADDR_W-1:0] q_addr [DEPTH];
   logic [DATA_W-1:0] q_data [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic [DEPTH-1:0]  slot_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         q_addr[wr_ptr] <= push_addr;
         q_data[wr_ptr] <= push_data;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [PTR_W-1:0] age;
         assign age         = PTR_W'(i) - rd_ptr;
         assign slot_hit[i] = ({1'b0, age} < count) && (q_addr[i] == probe_addr);
      end
   endgenerate

   assign probe_hit  = |slot_hit;
   assign head_valid = (count != '0);
   assign head_addr  = q_addr[rd_ptr];
   assign head_data  = q_data[rd_ptr];
   assign full       = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wt2_cache.sv
module wt2_cache #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int SETS     = 4,
   parameter int WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data,
   input  logic              wb_ready
);
   import cw_pkg::*;

   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int NWAYS = 2;

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("SETS must be a power of two, at least 2");
      end
      if (WB_DEPTH < 2 || (WB_DEPTH & (WB_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("WB_DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must leave at least one tag bit");
      end
   endgenerate

   cache_state_t state_q;

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic [NWAYS-1:0]  w_valid, hit_w, w_wr;
   logic [TAG_W-1:0]  w_tag  [NWAYS];
   logic [DATA_W-1:0] w_data [NWAYS];
   logic              hit, hit_way, victim;
   logic              buf_full, buf_match;
   logic              rd_done, st_acc, fill_done, start_fill;
   logic [DATA_W-1:0] wr_word;

   assign idx = cpu_addr[IDX_W-1:0];
   assign tag = cpu_addr[ADDR_W-1:IDX_W];

   assign fill_done  = (state_q == ST_FILL) && mem_rd_ack;
   assign wr_word    = fill_done ? mem_rd_data : cpu_wdata;

   generate
      for (genvar w = 0; w < NWAYS; w++) begin : g_way
         cw_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (idx),
            .rd_valid (w_valid[w]),
            .rd_tag   (w_tag[w]),
            .rd_data  (w_data[w]),
            .wr_en    (w_wr[w]),
            .wr_idx   (idx),
            .wr_tag   (tag),
            .wr_data  (wr_word)
         );
         assign hit_w[w] = w_valid[w] && (w_tag[w] == tag);
         assign w_wr[w]  = (fill_done && (victim == w[0])) || (st_acc && hit_w[w]);
      end
   endgenerate

   assign hit       = |hit_w;
   assign hit_way   = hit_w[1];
   assign cpu_rdata = hit_way ? w_data[1] : w_data[0];

   assign rd_done    = (state_q == ST_LOOKUP) && cpu_req && !cpu_we && hit;
   assign st_acc     = (state_q == ST_LOOKUP) && cpu_req && cpu_we && !buf_full;
   assign start_fill = (state_q == ST_LOOKUP) && cpu_req && !cpu_we && !hit && !buf_match;
   assign cpu_stall  = cpu_req && !(rd_done || st_acc);

   cw_lru_bits #(.SETS(SETS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (idx),
      .way0_valid (w_valid[0]),
      .way1_valid (w_valid[1]),
      .touch_en   (rd_done || (st_acc && hit)),
      .touch_way  (hit_way),
      .victim     (victim)
   );

   cw_store_queue #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (st_acc),
      .push_addr  (cpu_addr),
      .push_data  (cpu_wdata),
      .pop        (wb_valid && wb_ready),
      .head_valid (wb_valid),
      .head_addr  (wb_addr),
      .head_data  (wb_data),
      .full       (buf_full),
      .probe_addr (cpu_addr),
      .probe_hit  (buf_match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          state_q <= ST_LOOKUP;
      else if (start_fill) state_q <= ST_FILL;
      else if (fill_done)  state_q <= ST_LOOKUP;
   end

   assign mem_rd_req  = (state_q == ST_FILL);
   assign mem_rd_addr = cpu_addr;
endmodule

// File: rtl/wt2_cache_chk.sv
module wt2_cache_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int WB_DEPTH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_stall,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic              wb_valid,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [DATA_W-1:0] wb_data,
   input logic              wb_ready
);
   logic [15:0] occ;
   logic        push, pop;
   assign push = cpu_req && cpu_we && !cpu_stall;
   assign pop  = wb_valid && wb_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + {15'd0, push} - {15'd0, pop};
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !wb_valid && !mem_rd_req);

   p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

   p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

   p_empty_no_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      occ == 16'd0 |-> !wb_valid);

   p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && occ == 16'(WB_DEPTH) |-> cpu_stall);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 16'(WB_DEPTH));

   p_store_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we |-> !mem_rd_req);

   p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !cpu_stall |-> !mem_rd_req);
endmodule

bind wt2_cache wt2_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_req     (cpu_req),
   .cpu_we      (cpu_we),
   .cpu_stall   (cpu_stall),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_addr (mem_rd_addr),
   .mem_rd_ack  (mem_rd_ack),
   .wb_valid    (wb_valid),
   .wb_addr     (wb_addr),
   .wb_data     (wb_data),
   .wb_ready    (wb_ready)
);

// File: tb/wt2_cache_bench.sv
`timescale 1ns/100ps
module wt2_cache_bench;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_req, cpu_we;
   logic [AW-1:0] cpu_addr;
   logic [DW-1:0] cpu_wdata, cpu_rdata;
   logic          cpu_stall;
   logic          mem_rd_req, mem_rd_ack;
   logic [AW-1:0] mem_rd_addr;
   logic [DW-1:0] mem_rd_data;
   logic          wb_valid, wb_ready;
   logic [AW-1:0] wb_addr;
   logic [DW-1:0] wb_data;

   int total = 0;
   int bad   = 0;
   int fills = 0;
   int lat   = 0;

   logic [DW-1:0]      mem    [256];
   logic [DW-1:0]      refmem [256];
   logic [DW-1:0]      exp_rd [$];
   logic [AW+DW-1:0]   exp_wb [$];
   logic [DW-1:0]      e_rd;
   logic [AW+DW-1:0]   e_wb;

   always #2 clk = ~clk;

   wt2_cache u_wt2_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready)
   );

   task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // memory model: fill answered three falling edges after the request
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rd_ack <= 1'b0;
         lat        <= 0;
      end else begin
         mem_rd_ack <= 1'b0;
         if (mem_rd_req && !mem_rd_ack) begin
            if (lat == 2) begin
               mem_rd_ack  <= 1'b1;
               mem_rd_data <= mem[mem_rd_addr];
               lat         <= 0;
               fills       <= fills + 1;
            end else begin
               lat <= lat + 1;
            end
         end
      end
   end

   // monitor: read results
   always begin
      @(negedge clk);
      #1;
      if (rst_n && cpu_req && !cpu_we && !cpu_stall) begin
         if (exp_rd.size() == 0) chk(1'b0, "R3", 64'(cpu_rdata), 64'hx);
         else begin
            e_rd = exp_rd.pop_front();
            chk(cpu_rdata == e_rd, "R3", 64'(cpu_rdata), 64'(e_rd));
         end
      end
   end

   // monitor: drained stores, in order (R7)
   always begin
      @(negedge clk);
      #1;
      if (rst_n && wb_valid && wb_ready) begin
         if (exp_wb.size() == 0) chk(1'b0, "R7", 64'({wb_addr, wb_data}), 64'hx);
         else begin
            e_wb = exp_wb.pop_front();
            chk({wb_addr, wb_data} == e_wb, "R7", 64'({wb_addr, wb_data}), 64'(e_wb));
         end
         mem[wb_addr] = wb_data;
      end
   end

   task automatic access(input bit we, input int a, input logic [DW-1:0] d, output int waited);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = AW'(a);
      cpu_wdata = d;
      if (!we) exp_rd.push_back(refmem[a]);
      else begin
         refmem[a] = d;
         exp_wb.push_back({AW'(a), d});
      end
      #1;
      waited = 0;
      while (cpu_stall && waited < 2000) begin
         @(negedge clk);
         #1;
         waited++;
      end
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   task automatic rd(input int a);
      int w;
      access(1'b0, a, '0, w);
   endtask

   task automatic wait_drained();
      int n = 0;
      @(negedge clk);
      #1;
      while (wb_valid && n < 2000) begin
         @(negedge clk);
         #1;
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int f0, w, w5;
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      wb_ready = 1'b1; mem_rd_data = '0;
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 32'h1000_0000 + 32'(i * 7);
         refmem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!cpu_stall && !wb_valid && !mem_rd_req, "R1",
          64'({cpu_stall, wb_valid, mem_rd_req}), 64'd0);

      // R2 / R1: alternating conflict string in one set
      f0 = fills;
      for (int k = 0; k < 4; k++) begin
         rd(0);
         rd(4);
      end
      chk(fills - f0 == 2, "R2", 64'(fills - f0), 64'd2);

      // R4: third tag evicts the less recent way (0); then 4 hits, 0 misses
      f0 = fills; rd(8);  chk(fills - f0 == 1, "R4", 64'(fills - f0), 64'd1);
      f0 = fills; rd(4);  chk(fills - f0 == 0, "R3", 64'(fills - f0), 64'd0);
      f0 = fills; rd(0);  chk(fills - f0 == 1, "R4", 64'(fills - f0), 64'd1);

      // R5: store hit to 4 makes it most recent; 8 then evicts 0; 4 returns new word
      access(1'b1, 4, 32'hDEAD_0004, w);
      chk(w == 0, "R8", 64'(w), 64'd0);
      f0 = fills; rd(8);  chk(fills - f0 == 1, "R5", 64'(fills - f0), 64'd1);
      f0 = fills; rd(4);  chk(fills - f0 == 0, "R5", 64'(fills - f0), 64'd0);

      // R4: empty set fills both ways before any eviction
      f0 = fills; rd(1); rd(5); rd(1); rd(5);
      chk(fills - f0 == 2, "R4", 64'(fills - f0), 64'd2);

      // R6: store miss does not allocate and does not disturb residents
      access(1'b1, 21, 32'hBEEF_0021, w);
      wait_drained();
      f0 = fills; rd(1); rd(5);
      chk(fills - f0 == 0, "R6", 64'(fills - f0), 64'd0);
      f0 = fills; rd(21);
      chk(fills - f0 == 1, "R6", 64'(fills - f0), 64'd1);

      // R9: read miss waits for its own pending store to drain
      @(negedge clk) wb_ready = 1'b0;
      access(1'b1, 30, 32'hCAFE_0030, w);
      f0 = fills;
      fork
         rd(30);
         begin
            repeat (4) @(negedge clk);
            #1;
            chk(!mem_rd_req && cpu_stall, "R9", 64'({mem_rd_req, cpu_stall}), 64'b01);
            @(negedge clk);
            wb_ready = 1'b1;
         end
      join
      chk(fills - f0 == 1, "R10", 64'(fills - f0), 64'd1);

      // R8 / R7: four stores fit, the fifth stalls until the drain opens
      wait_drained();
      @(negedge clk) wb_ready = 1'b0;
      for (int k = 0; k < 4; k++) begin
         access(1'b1, 40 + k, 32'h5000_0000 + 32'(k), w);
         chk(w == 0, "R8", 64'(w), 64'd0);
      end
      fork
         access(1'b1, 44, 32'h5000_0004, w5);
         begin
            repeat (4) @(negedge clk);
            #1;
            chk(cpu_stall && wb_valid, "R8", 64'({cpu_stall, wb_valid}), 64'b11);
            @(negedge clk);
            wb_ready = 1'b1;
         end
      join
      chk(w5 >= 3, "R8", 64'(w5), 64'd3);
      wait_drained();
      rd(42);
      repeat (3) @(negedge clk);
      chk(exp_rd.size() == 0 && exp_wb.size() == 0, "R7",
          64'(exp_rd.size() + exp_wb.size()), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule